// File: doc/BRIEF.md
# Pixel Column Cluster Finder

This block examines one readout column of a binary pixel sensor on every crossing clock. The hit vector arrives already thresholded, one bit per pixel, and is qualified by a strobe. The block locates every run of adjacent hit pixels and classifies each run as narrow or wide against a configurable width limit of two or three pixels. A wide run cannot have come from a stiff, high transverse momentum track, so it is discarded and a flag is raised.

From the narrow runs, the one that starts at the lowest pixel index is reported. The report gives its centre as the sum of its first and last pixel indices, which yields half-pixel resolution in 8 bits for a 128-pixel column, and it gives its width. When more than one narrow run is present, an overflow flag is raised. Every result is registered and appears exactly one clock after the column that produced it.

The width limit is captured into an internal register only on cycles with no column strobe, or while reset is held. This keeps the setting steady across a stream of columns. A setting other than 2 is treated as 3.

Top module: `pixel_cluster_finder`

## Requirements
- R1: While reset is held and in the first cycle after it, clu_valid, clu_pos, clu_width, wide_reject and multi_overflow are all 0.
- R2: The outputs depend only on the column strobed one clock earlier. After a clock edge at which col_valid was 0, every output is 0, whatever the hits input held.
- R3: clu_valid is 1 exactly when the strobed column holds at least one narrow run. clu_pos is then the first pixel index plus the last pixel index of the reported run, with pixel 0 at hits bit 0.
- R4: clu_width gives the pixel count of the reported run, encoded as 1, 2 or 3, and never exceeds the active width limit.
- R5: When several narrow runs exist, the run with the lowest start index is reported and multi_overflow is 1. With zero or one narrow run, multi_overflow is 0.
- R6: A run longer than the active limit is never reported. wide_reject is 1 when the column holds at least one such run, and 0 otherwise.
- R7: With a limit of 2, a three-pixel run counts as wide. With a limit of 3, it counts as narrow.
- R8: max_width_cfg values 0, 1 and 3 all give a limit of 3, and only the value 2 gives a limit of 2.
- R9: max_width_cfg is captured only on a clock edge with col_valid 0 or rst 1. A change made while col_valid stays 1 has no effect until the next such edge.
- R10: Runs that touch pixel 0 or the last pixel are measured correctly. For example, a single hit at pixel 127 reports position 254 with width 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst | input | 1 | Synchronous active-high reset |
| col_valid | input | 1 | Strobe: hits holds a column to evaluate |
| hits | input | NPIX | Thresholded hit bits, bit i is pixel i |
| max_width_cfg | input | 2 | Requested maximum accepted run width |
| clu_valid | output | 1 | A narrow run is reported |
| clu_pos | output | POS_W | First plus last pixel index of the reported run |
| clu_width | output | 2 | Pixel count of the reported run |
| wide_reject | output | 1 | At least one over-wide run was discarded |
| multi_overflow | output | 1 | More than one narrow run was present |

## Verification
On every cycle, the assertions check that a result never appears without a strobe one clock earlier, and that a reported width lies between one and the active limit. They also check that the position parity agrees with the width, that the captured limit is always 2 or 3 and holds steady across strobed cycles, and that overflow never appears without a found run. Other behaviours can only be shown by the bench scenarios: the exact positions, the lowest-index choice among several runs, the run measurement at both column ends, the change of classification between limits, and the clamping of odd settings. To show these, the bench sweeps every hit pattern over ten pixels at each end of the column under both limits and compares the results against an arithmetic run-scanning model.

// File: rtl/cluster_pkg.sv
package cluster_pkg;

  localparam int WCODE_W = 2;

  typedef logic [WCODE_W-1:0] wcode_t;

  // Any request other than 2 becomes the wider limit of 3.
  function automatic wcode_t clamp_limit(input wcode_t req);
    return (req == 2'd2) ? 2'd2 : 2'd3;
  endfunction

endpackage

// File: rtl/cluster_run_classify.sv
module cluster_run_classify
  import cluster_pkg::*;
#(
  parameter int NPIX = 128
) (
  input  logic [NPIX-1:0]              hits,
  input  wcode_t                       limit,
  output logic [NPIX-1:0]              narrow,
  output logic [NPIX-1:0]              wide,
  output logic [NPIX-1:0][WCODE_W-1:0] wcode
);

  localparam int HX_W = NPIX + 4;

  // One zero guard bit below pixel 0 and three above the top pixel.
  logic [HX_W-1:0] hx;
  assign hx = {3'b000, hits, 1'b0};

  for (genvar g = 0; g < NPIX; g++) begin : g_pix
    logic start, h1, h2, h3;
    logic len1, len2, len3, longer;

    assign start  = hx[g+1] & ~hx[g];
    assign h1     = hx[g+2];
    assign h2     = hx[g+3];
    assign h3     = hx[g+4];
    assign len1   = start & ~h1;
    assign len2   = start & h1 & ~h2;
    assign len3   = start & h1 & h2 & ~h3;
    assign longer = start & h1 & h2 & h3;

    assign wide[g]   = longer | (len3 & (limit == 2'd2));
    assign narrow[g] = len1 | len2 | (len3 & (limit != 2'd2));
    assign wcode[g]  = len1 ? 2'd1 : (len2 ? 2'd2 : 2'd3);
  end

endmodule

// File: rtl/cluster_select.sv
module cluster_select
  import cluster_pkg::*;
#(
  parameter int NPIX  = 128,
  parameter int IDX_W = $clog2(NPIX)
) (
  input  logic [NPIX-1:0]              narrow,
  input  logic [NPIX-1:0][WCODE_W-1:0] wcode,
  output logic                         found,
  output logic [IDX_W-1:0]             idx,
  output wcode_t                       width,
  output logic                         ovf
);

  logic [NPIX-1:0] below;

  assign below = narrow & (narrow - NPIX'(1));
  assign found = |narrow;
  assign ovf   = |below;

  always_comb begin
    idx = '0;
    for (int i = NPIX - 1; i >= 0; i--) begin
      if (narrow[i]) idx = IDX_W'(i);
    end
  end

  assign width = wcode[idx];

  // R5: overflow can only accompany a found run
  always_comb begin
    a_ovf_needs_found_r5: assert (!(ovf && !found));
  end

endmodule

// File: rtl/pixel_cluster_finder.sv
module pixel_cluster_finder
  import cluster_pkg::*;
#(
  parameter int NPIX = 128
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      col_valid,
  input  logic [NPIX-1:0]           hits,
  input  logic [1:0]                max_width_cfg,
  output logic                      clu_valid,
  output logic [$clog2(2*NPIX-1)-1:0] clu_pos,
  output logic [1:0]                clu_width,
  output logic                      wide_reject,
  output logic                      multi_overflow
);

  localparam int IDX_W = $clog2(NPIX);
  localparam int POS_W = $clog2(2*NPIX-1);

  wcode_t                       cfg_q;
  logic [NPIX-1:0]              narrow, wide;
  logic [NPIX-1:0][WCODE_W-1:0] wcode;
  logic                         sel_found, sel_ovf;
  logic [IDX_W-1:0]             sel_idx;
  wcode_t                       sel_w;
  logic [POS_W-1:0]             pos_c;

  // Width limit is only captured when no column is being evaluated.
  always_ff @(posedge clk) begin
    if (rst || !col_valid) cfg_q <= clamp_limit(max_width_cfg);
  end

  cluster_run_classify #(.NPIX(NPIX)) u_classify (
    .hits   (hits),
    .limit  (cfg_q),
    .narrow (narrow),
    .wide   (wide),
    .wcode  (wcode)
  );

  cluster_select #(.NPIX(NPIX), .IDX_W(IDX_W)) u_select (
    .narrow (narrow),
    .wcode  (wcode),
    .found  (sel_found),
    .idx    (sel_idx),
    .width  (sel_w),
    .ovf    (sel_ovf)
  );

  assign pos_c = POS_W'({1'b0, sel_idx, 1'b0}) + POS_W'(sel_w) - POS_W'(1);

  always_ff @(posedge clk) begin
    if (rst || !col_valid) begin
      clu_valid      <= 1'b0;
      clu_pos        <= '0;
      clu_width      <= '0;
      wide_reject    <= 1'b0;
      multi_overflow <= 1'b0;
    end else begin
      clu_valid      <= sel_found;
      clu_pos        <= sel_found ? pos_c : '0;
      clu_width      <= sel_found ? sel_w : '0;
      wide_reject    <= |wide;
      multi_overflow <= sel_ovf;
    end
  end

  // R2: a result needs a strobed column one clock earlier
  p_valid_needs_strobe_r2: assert property (@(posedge clk) disable iff (rst)
    (clu_valid || wide_reject || multi_overflow) |-> $past(col_valid));

  // R4: reported width within 1 and the active limit
  p_width_in_limit_r4: assert property (@(posedge clk) disable iff (rst)
    clu_valid |-> (clu_width != 2'd0 && clu_width <= cfg_q));

  // R3: first+last index has odd parity exactly for even widths
  p_pos_parity_r3: assert property (@(posedge clk) disable iff (rst)
    clu_valid |-> (clu_pos[0] == ~clu_width[0]));

  // R8: captured limit is always 2 or 3
  p_limit_clamped_r8: assert property (@(posedge clk) disable iff (rst)
    (cfg_q == 2'd2 || cfg_q == 2'd3));

  // R9: limit steady across strobed cycles
  p_limit_held_r9: assert property (@(posedge clk) disable iff (rst)
    col_valid |=> $stable(cfg_q));

  // R5: overflow only alongside a reported run
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    multi_overflow |-> clu_valid);

endmodule

// File: tb/pixel_cluster_finder_tb.sv
module pixel_cluster_finder_tb;

  localparam int NPIX = 128;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             col_valid = 1'b0;
  logic [NPIX-1:0]  hits = '0;
  logic [1:0]       max_width_cfg = 2'd3;
  logic             clu_valid;
  logic [7:0]       clu_pos;
  logic [1:0]       clu_width;
  logic             wide_reject;
  logic             multi_overflow;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  pixel_cluster_finder #(.NPIX(NPIX)) u_dut (
    .clk            (clk),
    .rst            (rst),
    .col_valid      (col_valid),
    .hits           (hits),
    .max_width_cfg  (max_width_cfg),
    .clu_valid      (clu_valid),
    .clu_pos        (clu_pos),
    .clu_width      (clu_width),
    .wide_reject    (wide_reject),
    .multi_overflow (multi_overflow)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_zero(input string tag);
    chk({tag, " valid"}, int'(clu_valid), 0);
    chk({tag, " pos"}, int'(clu_pos), 0);
    chk({tag, " width"}, int'(clu_width), 0);
    chk({tag, " reject"}, int'(wide_reject), 0);
    chk({tag, " overflow"}, int'(multi_overflow), 0);
  endtask

  // Arithmetic run scan over the column.
  task automatic model(input logic [NPIX-1:0] h, input int lim,
                       output int v, output int pos, output int w,
                       output int ovf, output int rej);
    int i = 0;
    v = 0; pos = 0; w = 0; ovf = 0; rej = 0;
    while (i < NPIX) begin
      if (h[i]) begin
        int s = i;
        while (i < NPIX && h[i]) i++;
        if (i - s <= lim) begin
          if (v == 0) begin
            v = 1; pos = 2 * s + (i - s) - 1; w = i - s;
          end else ovf = 1;
        end else rej = 1;
      end else i++;
    end
  endtask

  // Called at a falling edge; strobes one column and checks it one clock later.
  task automatic apply(input logic [NPIX-1:0] h, input int lim, input string rq);
    int v, pos, w, ovf, rej;
    col_valid = 1'b1;
    hits = h;
    model(h, lim, v, pos, w, ovf, rej);
    @(negedge clk);
    chk({rq, " R3 valid"}, int'(clu_valid), v);
    chk({rq, " R3 pos"}, int'(clu_pos), pos);
    chk({rq, " R4 width"}, int'(clu_width), w);
    chk({rq, " R5 overflow"}, int'(multi_overflow), ovf);
    chk({rq, " R6 reject"}, int'(wide_reject), rej);
  endtask

  // Idle cycle: limit captured, outputs cleared.
  task automatic set_cfg(input logic [1:0] c);
    col_valid = 1'b0;
    hits = '1;
    max_width_cfg = c;
    @(negedge clk);
    chk_zero("R2 idle");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [NPIX-1:0] h;
    repeat (3) @(negedge clk);
    chk_zero("R1 in reset");
    rst = 1'b0;
    @(negedge clk);
    chk_zero("R1 after reset");

    // Exhaustive ten-pixel sweeps at both column ends, both limits (R7, R10)
    for (int lim = 2; lim <= 3; lim++) begin
      set_cfg(2'(lim));
      for (int p = 0; p < 1024; p++) begin
        h = NPIX'(p);
        apply(h, lim, lim == 2 ? "R7 lim2 low" : "R7 lim3 low");
        apply(h << (NPIX - 10), lim, "R10 high end");
      end
    end

    // R10 directed edges
    set_cfg(2'd3);
    h = '0; h[NPIX-1] = 1'b1;
    apply(h, 3, "R10 top single");
    chk("R10 pos 254", int'(clu_pos), 254);
    h = '0; h[0] = 1'b1; h[1] = 1'b1;
    apply(h, 3, "R10 bottom pair");
    chk("R10 pos 1", int'(clu_pos), 1);

    // R5 lowest index chosen among several
    h = '0; h[90] = 1'b1; h[40] = 1'b1; h[41] = 1'b1; h[70] = 1'b1;
    apply(h, 3, "R5 multi");
    chk("R5 pos 81", int'(clu_pos), 81);
    chk("R5 ovf", int'(multi_overflow), 1);

    // R6 wide run next to a narrow one, and a full column
    h = '0; h[20 +: 6] = '1; h[50] = 1'b1;
    apply(h, 3, "R6 mixed");
    chk("R6 pos 100", int'(clu_pos), 100);
    apply('1, 3, "R6 full");
    chk("R6 full valid", int'(clu_valid), 0);

    // R8 clamped settings 0 and 1 behave as 3
    for (int c = 0; c <= 1; c++) begin
      set_cfg(2'(c));
      h = '0; h[10 +: 3] = '1;
      apply(h, 3, "R8 three wide");
      chk("R8 accepted", int'(clu_valid), 1);
      h = '0; h[10 +: 4] = '1;
      apply(h, 3, "R8 four wide");
      chk("R8 rejected", int'(wide_reject), 1);
    end

    // R9 change while strobing has no effect until an idle edge
    set_cfg(2'd3);
    max_width_cfg = 2'd2;
    h = '0; h[5 +: 3] = '1;
    apply(h, 3, "R9 held");
    chk("R9 still limit 3", int'(clu_width), 3);
    apply(h, 3, "R9 held again");
    set_cfg(2'd2);
    apply(h, 2, "R9 after idle");
    chk("R9 now limit 2", int'(wide_reject), 1);

    // R2 strobe low with hits present gives zeros
    col_valid = 1'b0;
    h = '0; h[60] = 1'b1;
    hits = h;
    @(negedge clk);
    chk_zero("R2 no strobe");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule